// File: doc/BRIEF.md
# Profile-Switched Quadrature Carrier Modulator

This block is a digital upconversion stage. It takes baseband I and Q samples at the full clock rate and mixes them onto a carrier produced by a 32-bit phase accumulator. The I sample is multiplied by a cosine carrier and the Q sample by a sine carrier. The two products are then added or subtracted to form one real 14-bit output stream. The carrier frequency is the tuning word times the clock frequency divided by 2^32.

Four tuning profiles are held inside the block. Each profile has a 32-bit tuning word and a sign-flip bit for the Q product. A two-bit select input picks the active profile, and a switch takes effect on the very next accumulator step. A separate write port loads the profiles.

In tone mode the baseband inputs play no part and the cosine carrier itself becomes the output. The phase stays frozen until an update strobe arrives. The strobe then loads the selected tuning word into the accumulator and starts synthesis.

Top module: `qdm_modulator`

## Requirements
- R1: In modulator mode (tone_mode=0) the 32-bit accumulator advances by the selected profile's tuning word on every clock, wrapping modulo 2^32, and update_strobe has no effect.
- R2: A write with prof_wr_en=1 stores prof_wr_ftw and prof_wr_inv into the profile indexed by prof_wr_idx (0..3). The stored values are used from the following clock on.
- R3: prof_sel (0..3) selects the active profile combinationally. A change of prof_sel changes the step applied at the next edge, with no strobe.
- R4: Let c and s be the cosine and sine carriers. With the active profile's invert bit at 1 the mixed sum is i*c + q*s. With the bit at 0 it is i*c - q*s.
- R5: The phase index p is accumulator bits [31:20]. The sine carrier is round-half-away-from-zero(8191*sin(2*pi*(p+0.5)/4096)). The cosine carrier is the sine at index (p+1024) mod 4096, which is a 90 degree lead.
- R6: In tone mode (tone_mode=1) the output equals the cosine carrier, whatever i_in and q_in are.
- R7: In tone mode the accumulator holds its value until update_strobe is seen. A strobe loads the selected tuning word into the accumulator and starts free running. Modulator mode clears the running state, so each new entry into tone mode holds again until a strobe.
- R8: The mixed sum is rounded as floor((sum + 4096) / 8192) and saturated to the range -8192..8191.
- R9: Inputs, profile choice and accumulator value sampled at clock edge k determine the output seen after edge k+1.
- R10: A synchronous active-high reset clears the accumulator, the running state, all profiles (tuning word 0, invert 0) and the pipeline, so the output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_mode | input | 1 | 1 = tone mode, 0 = modulator mode |
| update_strobe | input | 1 | Starts or restarts synthesis in tone mode |
| prof_sel | input | 2 | Active profile index |
| prof_wr_en | input | 1 | Profile write enable |
| prof_wr_idx | input | 2 | Profile index to write |
| prof_wr_ftw | input | 32 | Tuning word to store |
| prof_wr_inv | input | 1 | Q-sign invert bit to store |
| i_in | input | 14 | Signed I sample |
| q_in | input | 14 | Signed Q sample |
| mod_out | output | 14 | Signed modulated or tone sample |

## Verification
The embedded assertions check accumulator sequencing on every cycle: free running in modulator mode, holding while tone mode waits for a strobe, and loading on a strobe. They also check that a write to the active profile reaches the accumulator step, and that tone mode forwards the registered cosine. The carrier table values, the invert-bit sign, rounding, saturation and the two-cycle latency are arithmetic results. Only the bench's per-cycle comparison against an independent model can show them, using sweeps of profile switches, full-scale inputs and tone-mode restarts.

// File: rtl/qdm_pkg.sv
package qdm_pkg;
    localparam int ACC_W  = 32;
    localparam int PH_W   = 12;
    localparam int SMP_W  = 14;
    localparam int NPROF  = 4;
    localparam int SEL_W  = $clog2(NPROF);
    localparam int QTR_W  = PH_W - 2;
    localparam int QTR_N  = 1 << QTR_W;
    localparam int MAG_W  = SMP_W - 1;
    localparam int PROD_W = 2 * SMP_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam real PI_R  = 3.14159265358979323846;

    typedef logic [ACC_W-1:0]        ftw_t;
    typedef logic signed [SMP_W-1:0] smp_t;

    typedef struct packed {
        ftw_t ftw;
        logic inv;
    } prof_t;

    typedef struct packed {
        smp_t i;
        smp_t q;
        logic inv;
        logic tone;
    } stage_t;

    typedef struct packed {
        smp_t s;
        smp_t c;
    } carrier_t;

    // magnitude of the first sine quadrant, half-index offset for exact symmetry
    function automatic logic [MAG_W-1:0] quarter_mag(int k);
        real amp;
        real x;
        amp = real'((1 << MAG_W) - 1);
        x   = amp * $sin(2.0 * PI_R * (real'(k) + 0.5) / real'(1 << PH_W));
        return MAG_W'($rtoi(x + 0.5));
    endfunction

    // round to nearest (half up) with a right shift, then clamp to sample range
    function automatic smp_t round_sat(logic signed [SUM_W-1:0] v);
        localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (MAG_W - 1);
        localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << MAG_W) - 1);
        localparam logic signed [SUM_W-1:0] MINV = -MAXV - SUM_W'(1);
        logic signed [SUM_W-1:0] sh;
        sh = (v + HALF) >>> MAG_W;
        if (sh > MAXV)      return smp_t'(MAXV);
        else if (sh < MINV) return smp_t'(MINV);
        else                return smp_t'(sh);
    endfunction
endpackage

// File: rtl/qdm_profile_bank.sv
module qdm_profile_bank
    import qdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  ftw_t             wr_ftw,
    input  logic             wr_inv,
    input  logic [SEL_W-1:0] sel,
    output prof_t            active
);
    prof_t bank [NPROF];

    for (genvar g = 0; g < NPROF; g++) begin : g_prof
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (wr_en && wr_idx == SEL_W'(g)) begin
                bank[g] <= '{ftw: wr_ftw, inv: wr_inv};
            end
        end
    end

    assign active = bank[sel];

    // write into the selected slot is visible on the next cycle
    p_write_visible_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == sel) |=> (sel != $past(sel)) ||
                                     (active.ftw == $past(wr_ftw) && active.inv == $past(wr_inv)));
endmodule

// File: rtl/qdm_phase_acc.sv
module qdm_phase_acc
    import qdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tone,
    input  logic strobe,
    input  ftw_t step,
    output ftw_t acc
);
    logic run;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            run <= 1'b0;
        end else if (!tone) begin
            run <= 1'b0;
            acc <= acc + step;
        end else if (strobe) begin
            run <= 1'b1;
            acc <= step;
        end else if (run) begin
            acc <= acc + step;
        end
    end

    p_free_run_r1: assert property (@(posedge clk) disable iff (rst)
        !tone |=> acc == $past(acc) + $past(step));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tone && !strobe && !run) |=> $stable(acc));

    p_strobe_load_r7: assert property (@(posedge clk) disable iff (rst)
        (tone && strobe) |=> acc == $past(step));
endmodule

// File: rtl/qdm_trig_rom.sv
module qdm_trig_rom
    import qdm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] phase,
    output carrier_t        car
);
    localparam logic [PH_W-1:0] QUARTER = PH_W'(QTR_N);

    logic [MAG_W-1:0] tab [QTR_N];

    for (genvar g = 0; g < QTR_N; g++) begin : g_tab
        localparam logic [MAG_W-1:0] V = quarter_mag(g);
        assign tab[g] = V;
    end

    function automatic smp_t sine_of(logic [PH_W-1:0] p);
        logic [QTR_W-1:0] idx;
        smp_t mag;
        idx = p[PH_W-2] ? ~p[QTR_W-1:0] : p[QTR_W-1:0];
        mag = smp_t'({1'b0, tab[idx]});
        return p[PH_W-1] ? -mag : mag;
    endfunction

    smp_t sin_c, cos_c;
    assign sin_c = sine_of(phase);
    assign cos_c = sine_of(phase + QUARTER);

    always_ff @(posedge clk) begin
        if (rst) car <= '0;
        else     car <= '{s: sin_c, c: cos_c};
    end
endmodule

// File: rtl/qdm_mixer.sv
module qdm_mixer
    import qdm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  smp_t     i_in,
    input  smp_t     q_in,
    input  logic     inv,
    input  logic     tone,
    input  carrier_t car,
    output smp_t     out
);
    stage_t st;

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= '{i: i_in, q: q_in, inv: inv, tone: tone};
    end

    logic signed [PROD_W-1:0] prod_i, prod_q;
    logic signed [SUM_W-1:0]  sum;

    assign prod_i = st.i * car.c;
    assign prod_q = st.q * car.s;
    assign sum    = st.inv ? (SUM_W'(prod_i) + SUM_W'(prod_q))
                           : (SUM_W'(prod_i) - SUM_W'(prod_q));

    always_ff @(posedge clk) begin
        if (rst)          out <= '0;
        else if (st.tone) out <= car.c;
        else              out <= round_sat(sum);
    end

    p_tone_passthru_r6: assert property (@(posedge clk) disable iff (rst)
        st.tone |=> out == $past(car.c));
endmodule

// File: rtl/qdm_modulator.sv
module qdm_modulator
    import qdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tone_mode,
    input  logic                update_strobe,
    input  logic [1:0]          prof_sel,
    input  logic                prof_wr_en,
    input  logic [1:0]          prof_wr_idx,
    input  logic [31:0]         prof_wr_ftw,
    input  logic                prof_wr_inv,
    input  logic signed [13:0]  i_in,
    input  logic signed [13:0]  q_in,
    output logic signed [13:0]  mod_out
);
    prof_t    active;
    ftw_t     acc;
    carrier_t car;

    qdm_profile_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (prof_wr_en),
        .wr_idx (prof_wr_idx),
        .wr_ftw (prof_wr_ftw),
        .wr_inv (prof_wr_inv),
        .sel    (prof_sel),
        .active (active)
    );

    qdm_phase_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .tone   (tone_mode),
        .strobe (update_strobe),
        .step   (active.ftw),
        .acc    (acc)
    );

    qdm_trig_rom u_rom (
        .clk   (clk),
        .rst   (rst),
        .phase (acc[ACC_W-1 -: PH_W]),
        .car   (car)
    );

    qdm_mixer u_mix (
        .clk  (clk),
        .rst  (rst),
        .i_in (i_in),
        .q_in (q_in),
        .inv  (active.inv),
        .tone (tone_mode),
        .car  (car),
        .out  (mod_out)
    );
endmodule

// File: tb/qdm_modulator_test.sv
`timescale 1ns/1ps
module qdm_modulator_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tone_mode = 1'b0;
    logic update_strobe = 1'b0;
    logic [1:0] prof_sel = 2'd0;
    logic prof_wr_en = 1'b0;
    logic [1:0] prof_wr_idx = 2'd0;
    logic [31:0] prof_wr_ftw = 32'd0;
    logic prof_wr_inv = 1'b0;
    logic signed [13:0] i_in = 14'sd0;
    logic signed [13:0] q_in = 14'sd0;
    logic signed [13:0] mod_out;

    qdm_modulator uut (
        .clk(clk), .rst(rst), .tone_mode(tone_mode), .update_strobe(update_strobe),
        .prof_sel(prof_sel), .prof_wr_en(prof_wr_en), .prof_wr_idx(prof_wr_idx),
        .prof_wr_ftw(prof_wr_ftw), .prof_wr_inv(prof_wr_inv),
        .i_in(i_in), .q_in(q_in), .mod_out(mod_out)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int sat_seen = 0;
    bit active = 1'b0;
    bit done = 1'b0;
    string cur_req = "R10";

    // behavioural reference state
    logic [31:0] m_acc = 32'd0;
    bit m_run = 1'b0;
    logic [31:0] m_ftw [4] = '{default: 32'd0};
    bit m_inv [4] = '{default: 1'b0};
    int pipe [$] = '{0, 0};
    int expv = 0;

    function automatic int ref_sine(int p);
        real x;
        x = 8191.0 * $sin(2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 4096.0);
        if (x >= 0.0) return $rtoi(x + 0.5);
        else          return -$rtoi(-x + 0.5);
    endfunction

    function automatic int ref_mix(int i, int q, int c, int s, bit inv);
        longint sum;
        longint r;
        sum = inv ? (longint'(i) * c + longint'(q) * s) : (longint'(i) * c - longint'(q) * s);
        r = (sum + 4096) >>> 13;
        if (r > 8191)  r = 8191;
        if (r < -8192) r = -8192;
        return int'(r);
    endfunction

    always @(posedge clk) begin
        int ph, c, s, r, sel;
        if (rst) begin
            m_acc = 32'd0;
            m_run = 1'b0;
            for (int k = 0; k < 4; k++) begin m_ftw[k] = 32'd0; m_inv[k] = 1'b0; end
            pipe = '{0, 0};
        end else begin
            sel = int'(prof_sel);
            ph = int'(m_acc >> 20);
            s = ref_sine(ph);
            c = ref_sine((ph + 1024) % 4096);
            r = tone_mode ? c : ref_mix(int'(i_in), int'(q_in), c, s, m_inv[sel]);
            pipe.push_back(r);
            void'(pipe.pop_front());
            if (!tone_mode) begin
                m_run = 1'b0;
                m_acc = m_acc + m_ftw[sel];
            end else if (update_strobe) begin
                m_run = 1'b1;
                m_acc = m_ftw[sel];
            end else if (m_run) begin
                m_acc = m_acc + m_ftw[sel];
            end
            if (prof_wr_en) begin
                m_ftw[prof_wr_idx] = prof_wr_ftw;
                m_inv[prof_wr_idx] = prof_wr_inv;
            end
        end
        expv = pipe[0];
    end

    // per-cycle comparison, sampled mid-period
    always @(negedge clk) begin
        if (active && !done) begin
            checks++;
            if (int'(mod_out) != expv) begin
                fails++;
                $display("FAIL %s: mod_out=%0d expected %0d at %0t", cur_req, mod_out, expv, $time);
            end
            if (expv == 8191 || expv == -8192) sat_seen++;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_prof(int idx, logic [31:0] ftw, bit inv);
        prof_wr_en = 1'b1; prof_wr_idx = 2'(idx); prof_wr_ftw = ftw; prof_wr_inv = inv;
        cyc(1);
        prof_wr_en = 1'b0;
    endtask

    task automatic rand_iq(int n);
        for (int k = 0; k < n; k++) begin
            i_in = 14'($urandom); q_in = 14'($urandom);
            cyc(1);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run incomplete, expected finish before timeout");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        active = 1'b1;
        cur_req = "R10"; cyc(3);
        rst = 1'b0;
        cur_req = "R2";
        write_prof(0, 32'h0100_0000, 1'b0);
        write_prof(1, 32'h2000_0000, 1'b1);
        write_prof(2, 32'h0123_4567, 1'b0);
        write_prof(3, 32'h7FFF_FFFF, 1'b1);
        cur_req = "R1"; prof_sel = 2'd0; i_in = 14'sd3000; q_in = -14'sd2000; cyc(40);
        update_strobe = 1'b1; cyc(5); update_strobe = 1'b0;
        cur_req = "R4"; prof_sel = 2'd1; rand_iq(60);
        prof_sel = 2'd2; rand_iq(40);
        cur_req = "R3";
        for (int k = 0; k < 30; k++) begin
            prof_sel = 2'($urandom); rand_iq(3);
        end
        cur_req = "R8"; prof_sel = 2'd1; i_in = 14'sd8191; q_in = 14'sd8191; cyc(40);
        i_in = -14'sd8192; q_in = -14'sd8192; cyc(20);
        prof_sel = 2'd2; i_in = -14'sd8192; q_in = 14'sd8191; cyc(40);
        cur_req = "R5"; write_prof(2, 32'h4000_0000, 1'b0);
        i_in = 14'sd8191; q_in = 14'sd0; cyc(20);
        write_prof(2, 32'h0000_1000, 1'b1); i_in = 14'sd0; q_in = 14'sd8191; cyc(30);
        cur_req = "R9"; prof_sel = 2'd0; i_in = 14'sd5000; q_in = 14'sd0; cyc(1);
        i_in = 14'sd0; cyc(6);
        cur_req = "R7"; tone_mode = 1'b1; prof_sel = 2'd2; rand_iq(20);
        cur_req = "R6"; update_strobe = 1'b1; rand_iq(1); update_strobe = 1'b0;
        write_prof(2, 32'h0765_4321, 1'b0);
        rand_iq(40);
        prof_sel = 2'd3; rand_iq(10); prof_sel = 2'd1; rand_iq(10);
        cur_req = "R7"; update_strobe = 1'b1; rand_iq(1); update_strobe = 1'b0; rand_iq(15);
        tone_mode = 1'b0; cur_req = "R1"; rand_iq(10);
        tone_mode = 1'b1; cur_req = "R7"; rand_iq(12);
        update_strobe = 1'b1; rand_iq(1); update_strobe = 1'b0; rand_iq(20);
        cur_req = "R2"; tone_mode = 1'b0; prof_sel = 2'd0;
        prof_wr_en = 1'b1; prof_wr_idx = 2'd0; prof_wr_ftw = 32'h1111_1111; prof_wr_inv = 1'b1;
        rand_iq(1); prof_wr_en = 1'b0; rand_iq(20);
        cur_req = "R10"; rst = 1'b1; rand_iq(3); rst = 1'b0; rand_iq(2);
        i_in = 14'sd4000; q_in = 14'sd4000; cyc(10);
        cur_req = "R8";
        checks++;
        if (sat_seen == 0) begin
            fails++;
            $display("FAIL R8: saturated outputs seen=%0d expected >0", sat_seen);
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule